// File: doc/BRIEF.md
# Dual-Rate Active Rule Address Generator

This block sits between the fuzzy-set pair selector and the rule memory of a two-input fuzzy controller whose inputs each carry seven overlapping sets. For every input sample only four rules can fire. These are the pairings of the two active sets of input 0 with the two active sets of input 1. The pair selector computes all the set indices and region bits at once. This block takes them as one sample and spreads them over two core clocks, putting out two rule-base addresses per clock on an even lane and an odd lane.

In the first output cycle, input 0 is held at its even-indexed active set. The even lane then carries the rule paired with the even set of input 1, and the odd lane the rule paired with the odd set of input 1. In the second cycle, input 0 moves to its odd-indexed active set. Alongside each address pair the block gives the region select bits that the membership generators need. It also gives a first-rule flag, which clears the downstream integrators at the start of each sample.

The sample input is a valid/ready stream. `in_ready` is low only during the first output cycle of a sample, so a new sample can be taken every second clock and the output runs without gaps. A valid presented while ready is low is not taken. The source must hold it or drop it. The output has no back-pressure: each accepted sample produces exactly two valid beats on consecutive cycles, and the consumer must take both.

Top module: `fuzzy_rule_addr_gen`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Whenever `out_valid` is 0, `in_ready` is 1.
- R2: A sample accepted at a clock edge (`in_valid` and `in_ready` both 1) appears in the next cycle with `out_valid`=1 and `out_first`=1. In that beat `out_addr_even` = x0_set_even*7 + x1_set_even and `out_addr_odd` = x0_set_even*7 + x1_set_odd.
- R3: The beat right after a first beat has `out_valid`=1 and `out_first`=0. In it `out_addr_even` = x0_set_odd*7 + x1_set_even and `out_addr_odd` = x0_set_odd*7 + x1_set_odd.
- R4: A rule address is the input-0 set index times the set count (7) plus the input-1 set index. It is 6 bits wide, and its range is 0 to 48 when every index is below 7.
- R5: `in_ready` is 0 during a first beat. A valid presented in that cycle is not taken, and it produces no output beats.
- R6: `in_ready` is 1 during a second beat. A sample accepted then gives its first beat in the very next cycle, with no gap in `out_valid`.
- R7: `out_sel0` equals x0_reg_even in the first beat and x0_reg_odd in the second beat. `out_sel1_even` and `out_sel1_odd` equal x1_reg_even and x1_reg_odd in both beats.
- R8: Each accepted sample produces exactly two valid beats. A beat with `out_first`=0 only ever follows a beat with `out_first`=1.
- R9: The four addresses of one sample are exactly the cross product of {x0_set_even, x0_set_odd} with {x1_set_even, x1_set_odd}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample on the set and region inputs is valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| x0_set_even | input | 3 | Even-indexed active set of input 0 |
| x0_set_odd | input | 3 | Odd-indexed active set of input 0 |
| x1_set_even | input | 3 | Even-indexed active set of input 1 |
| x1_set_odd | input | 3 | Odd-indexed active set of input 1 |
| x0_reg_even | input | 1 | Region bit of input 0 for its even set |
| x0_reg_odd | input | 1 | Region bit of input 0 for its odd set |
| x1_reg_even | input | 1 | Region bit of input 1 for its even set |
| x1_reg_odd | input | 1 | Region bit of input 1 for its odd set |
| out_valid | output | 1 | Address beat valid |
| out_first | output | 1 | First beat of a sample; clears integrators |
| out_addr_even | output | 6 | Rule address on the even lane |
| out_addr_odd | output | 6 | Rule address on the odd lane |
| out_sel0 | output | 1 | Region select for the current input-0 set |
| out_sel1_even | output | 1 | Region select for input 1, even lane |
| out_sel1_odd | output | 1 | Region select for input 1, odd lane |

## Verification
The checker watches the beat protocol on every cycle:
- ready is high whenever the output is idle;
- acceptance leads to a first beat, and a first beat is always followed by a second;
- ready is low during a first beat;
- addresses stay within the rule base;
- the input-1 part of each lane and the input-1 selects hold steady across the two beats of a sample.

The scoreboard is needed for the rest:
- the exact address arithmetic, and which input-0 set each beat carries;
- the cross-product coverage of the four addresses;
- that a valid offered during a first beat produces no extra beats;
- that samples accepted back to back run without gaps.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } rag_phase_e;
endpackage

// File: rtl/rag_sequencer.sv
module rag_sequencer
  import rag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic take,
  output logic beat_valid,
  output logic beat_first
);
  rag_phase_e phase_q, phase_d;

  assign in_ready   = (phase_q != PH_FIRST);
  assign take       = in_valid && in_ready;
  assign beat_valid = (phase_q != PH_IDLE);
  assign beat_first = (phase_q == PH_FIRST);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (take) phase_d = PH_FIRST;
      PH_FIRST:  phase_d = PH_SECOND;
      PH_SECOND: phase_d = take ? PH_FIRST : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/rag_hold.sv
module rag_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/rag_lane_addr.sv
module rag_lane_addr #(
  parameter int SETS   = 7,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic [IDX_W-1:0]  row_idx,
  input  logic [IDX_W-1:0]  col_idx,
  output logic [ADDR_W-1:0] addr
);
  assign addr = ADDR_W'(row_idx) * ADDR_W'(SETS) + ADDR_W'(col_idx);
endmodule

// File: rtl/fuzzy_rule_addr_gen.sv
module fuzzy_rule_addr_gen #(
  parameter int SETS   = 7,
  parameter int IDX_W  = $clog2(SETS),
  parameter int ADDR_W = $clog2(SETS * SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  x0_set_even,
  input  logic [IDX_W-1:0]  x0_set_odd,
  input  logic [IDX_W-1:0]  x1_set_even,
  input  logic [IDX_W-1:0]  x1_set_odd,
  input  logic              x0_reg_even,
  input  logic              x0_reg_odd,
  input  logic              x1_reg_even,
  input  logic              x1_reg_odd,
  output logic              out_valid,
  output logic              out_first,
  output logic [ADDR_W-1:0] out_addr_even,
  output logic [ADDR_W-1:0] out_addr_odd,
  output logic              out_sel0,
  output logic              out_sel1_even,
  output logic              out_sel1_odd
);
  localparam int LANES  = 2;
  localparam int HOLD_W = 4 * IDX_W + 4;

  logic              take;
  logic [HOLD_W-1:0] hold_d, hold_q;
  logic [IDX_W-1:0]  h0_even, h0_odd, h1_even, h1_odd;
  logic              hr0_even, hr0_odd, hr1_even, hr1_odd;
  logic [IDX_W-1:0]  row_now;
  logic [IDX_W-1:0]  col_sel [LANES];
  logic [ADDR_W-1:0] lane_addr [LANES];

  rag_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .take       (take),
    .beat_valid (out_valid),
    .beat_first (out_first)
  );

  assign hold_d = {x0_set_even, x0_set_odd, x1_set_even, x1_set_odd,
                   x0_reg_even, x0_reg_odd, x1_reg_even, x1_reg_odd};

  rag_hold #(.W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .d     (hold_d),
    .q     (hold_q)
  );

  assign {h0_even, h0_odd, h1_even, h1_odd,
          hr0_even, hr0_odd, hr1_even, hr1_odd} = hold_q;

  // input 0 walks even set then odd set; input 1 is split across lanes
  assign row_now    = out_first ? h0_even : h0_odd;
  assign col_sel[0] = h1_even;
  assign col_sel[1] = h1_odd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rag_lane_addr #(.SETS(SETS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_addr (
      .row_idx (row_now),
      .col_idx (col_sel[g]),
      .addr    (lane_addr[g])
    );
  end

  assign out_addr_even = lane_addr[0];
  assign out_addr_odd  = lane_addr[1];
  assign out_sel0      = out_first ? hr0_even : hr0_odd;
  assign out_sel1_even = hr1_even;
  assign out_sel1_odd  = hr1_odd;
endmodule

// File: rtl/rag_checker.sv
module rag_checker #(
  parameter int SETS   = 7,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_first,
  input logic [ADDR_W-1:0] out_addr_even,
  input logic [ADDR_W-1:0] out_addr_odd,
  input logic              out_sel1_even,
  input logic              out_sel1_odd
);
  localparam int RULES = SETS * SETS;

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_first_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_first));

  assert_second_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |=> (out_valid && !out_first));

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_addr_even) < RULES && int'(out_addr_odd) < RULES));

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> !in_ready);

  assert_col_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |->
      ($stable(out_sel1_even) && $stable(out_sel1_odd) &&
       $stable(ADDR_W'(out_addr_odd - out_addr_even))));

  assert_pairing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> $past(out_valid && out_first));
endmodule

bind fuzzy_rule_addr_gen rag_checker #(.SETS(SETS), .ADDR_W(ADDR_W)) u_rag_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_first     (out_first),
  .out_addr_even (out_addr_even),
  .out_addr_odd  (out_addr_odd),
  .out_sel1_even (out_sel1_even),
  .out_sel1_odd  (out_sel1_odd)
);

// File: tb/fuzzy_rule_addr_gen_test.sv
`timescale 1ns/1ps
module fuzzy_rule_addr_gen_test;
  localparam int SETS = 7;

  typedef struct {
    logic       first;
    logic [5:0] ae;
    logic [5:0] ao;
    logic       s0;
    logic       s1e;
    logic       s1o;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] x0e = '0, x0o = '0, x1e = '0, x1o = '0;
  logic r0e = 1'b0, r0o = 1'b0, r1e = 1'b0, r1o = 1'b0;
  logic out_valid, out_first, out_sel0, out_sel1_even, out_sel1_odd;
  logic [5:0] out_addr_even, out_addr_odd;

  int checks = 0;
  int errors = 0;
  int busy_left = 0;
  bit done = 1'b0;
  beat_t exp_q[$];
  logic [63:0] mask_q[$];
  logic [63:0] seen_mask = '0;

  always #2 clk = ~clk;

  fuzzy_rule_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x0_set_even(x0e), .x0_set_odd(x0o), .x1_set_even(x1e), .x1_set_odd(x1o),
    .x0_reg_even(r0e), .x0_reg_odd(r0o), .x1_reg_even(r1e), .x1_reg_odd(r1o),
    .out_valid(out_valid), .out_first(out_first),
    .out_addr_even(out_addr_even), .out_addr_odd(out_addr_odd),
    .out_sel0(out_sel0), .out_sel1_even(out_sel1_even), .out_sel1_odd(out_sel1_odd)
  );

  function automatic logic [5:0] rule(input int a, input int b);
    return 6'(a * SETS + b);
  endfunction

  task automatic step();
    @(posedge clk); #1;
    if (busy_left > 0) busy_left--;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  // called one ns after a rising edge
  task automatic send(input int a0e, input int a0o, input int a1e, input int a1o,
                      input logic g0e, input logic g0o, input logic g1e, input logic g1o);
    bit exp_rdy;
    beat_t b;
    logic [63:0] m;
    x0e = 3'(a0e); x0o = 3'(a0o); x1e = 3'(a1e); x1o = 3'(a1o);
    r0e = g0e; r0o = g0o; r1e = g1e; r1o = g1o;
    in_valid = 1'b1;
    exp_rdy = (busy_left != 2);
    @(negedge clk);
    checks++;
    if (in_ready !== exp_rdy) begin
      errors++;
      $display("FAIL R5 R6 in_ready: actual %0b expected %0b", in_ready, exp_rdy);
    end
    if (exp_rdy) begin
      b = '{1'b1, rule(a0e, a1e), rule(a0e, a1o), g0e, g1e, g1o};
      exp_q.push_back(b);
      b = '{1'b0, rule(a0o, a1e), rule(a0o, a1o), g0o, g1e, g1o};
      exp_q.push_back(b);
      m = '0;
      m[a0e*SETS + a1e] = 1'b1; m[a0e*SETS + a1o] = 1'b1;
      m[a0o*SETS + a1e] = 1'b1; m[a0o*SETS + a1o] = 1'b1;
      mask_q.push_back(m);
    end
    step();
    if (exp_rdy) busy_left = 2;
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      beat_t e;
      logic [63:0] em;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected beat: actual valid=1 expected valid=0");
      end else begin
        e = exp_q.pop_front();
        if (out_first !== e.first || out_addr_even !== e.ae || out_addr_odd !== e.ao ||
            out_sel0 !== e.s0 || out_sel1_even !== e.s1e || out_sel1_odd !== e.s1o) begin
          errors++;
          $display("FAIL %s R4 R7 beat: actual f=%0b ae=%0d ao=%0d s0=%0b s1e=%0b s1o=%0b expected f=%0b ae=%0d ao=%0d s0=%0b s1e=%0b s1o=%0b",
                   e.first ? "R2" : "R3", out_first, out_addr_even, out_addr_odd,
                   out_sel0, out_sel1_even, out_sel1_odd,
                   e.first, e.ae, e.ao, e.s0, e.s1e, e.s1o);
        end
        if (e.first) seen_mask = '0;
        seen_mask[out_addr_even] = 1'b1;
        seen_mask[out_addr_odd]  = 1'b1;
        if (!e.first && mask_q.size() > 0) begin
          em = mask_q.pop_front();
          checks++;
          if (seen_mask !== em) begin
            errors++;
            $display("FAIL R9 rule set: actual %h expected %h", seen_mask, em);
          end
        end
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, in_ready);
    end
    step();
    // R4 lowest corner: address 0
    send(0, 1, 0, 1, 1'b0, 1'b1, 1'b0, 1'b1);
    idle(3);
    // R4 highest corner: address 48
    send(6, 5, 6, 5, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(3);
    // R5: a valid during the first beat is not taken
    send(2, 3, 4, 3, 1'b1, 1'b1, 1'b0, 1'b0);
    send(1, 0, 1, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R5 ignored sample produced beats: actual valid=%0b expected 0", out_valid);
    end
    idle(1);
    // R6: back-to-back samples every second clock
    send(4, 5, 2, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1);
    send(3, 2, 6, 5, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(1);
    send(5, 6, 0, 1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(3);
    // varied patterns with random gaps (a gap of 0 tests rejection)
    for (int k = 0; k < 30; k++) begin
      int p0, p1;
      p0 = int'($urandom_range(0, 5));
      p1 = int'($urandom_range(0, 5));
      send(p0 + (p0 % 2), p0 + 1 - (p0 % 2), p1 + (p1 % 2), p1 + 1 - (p1 % 2),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      idle(int'($urandom_range(0, 2)));
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing beats: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule